// File: doc/BRIEF.md
# UART Receiver Line Status Logic

This block holds the receive-side status flags of a UART: data ready, overrun, parity error, framing error and break. It sits between the receive shift register and the receive store, which is either a single holding register or a FIFO. Each time the shift register finishes a character, the block decides whether the store may take it. It raises overrun when the character has nowhere to go, and it keeps the per-character error flags sticky until software reads the status. The FIFO storage lives outside the block. The block sees the FIFO only through its full, empty and count signals, and through the error tags of the character at the FIFO head.

In holding-register mode, data ready follows the single register. A new character always replaces the old one, and overrun marks that the old character was lost. In FIFO mode, the block refuses a character only when the FIFO is full. That character then stays in the shift register and is lost. An error flag is raised when its character becomes the oldest entry in the FIFO. Every error flag clears when the status is read. If a new event arrives in the same cycle as the read, the new event is kept. A line status interrupt request is raised while any of the four error flags is set.

Top module: `uart_rx_line_status`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `data_ready`, `overrun`, `parity_err`, `framing_err`, `break_int` and `line_irq` are all 0.
- R2: With `fifo_mode` low, a `char_done` pulse sets `data_ready` in the next cycle. A `rbr_read` without `char_done` clears it in the next cycle.
- R3: With `fifo_mode` high, `data_ready` is 1 in a cycle exactly when the FIFO held at least one character after the previous clock edge. That occupancy is `fifo_count` plus one if a character was stored, minus one if `rbr_read` removed one from a non-empty FIFO.
- R4: With `fifo_mode` low, `char_done` while `data_ready` is 1 and `rbr_read` is 0 sets `overrun` in the next cycle. The new character is still stored.
- R5: With `fifo_mode` high, `char_done` while `fifo_full` is 1 and `rbr_read` is 0 keeps `store_en` low in that cycle and sets `overrun` in the next. The FIFO contents stay unchanged. When `rbr_read` is 1 in the same cycle, the character is stored and no overrun occurs.
- R6: `store_en` is a combinational output, high in the same cycle as an accepted `char_done` and low in every other cycle.
- R7: With `fifo_mode` low, the flags `char_par_err`, `char_frm_err` and `char_brk` presented with `char_done` set `parity_err`, `framing_err` and `break_int` in the next cycle.
- R8: With `fifo_mode` high, `head_err` (bit 0 parity, bit 1 framing, bit 2 break) is sampled in the cycle after the FIFO head changes. The head changes when a character is pushed into an empty FIFO, when a pop leaves at least one character, or when a push and a pop happen together at count 1. The matching flags are set in the cycle after that sample.
- R9: `lsr_read` clears `overrun`, `parity_err`, `framing_err` and `break_int` in the next cycle. A set event in the same cycle wins for its own flag.
- R10: `line_irq` equals the OR of `overrun`, `parity_err`, `framing_err` and `break_int` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1: FIFO store, 0: single holding register |
| char_done | input | 1 | Shift register finished a character (one-cycle pulse) |
| char_par_err | input | 1 | Parity error of the finished character |
| char_frm_err | input | 1 | Framing error of the finished character |
| char_brk | input | 1 | Break seen on the finished character |
| fifo_full | input | 1 | Receive FIFO is full |
| fifo_empty | input | 1 | Receive FIFO is empty |
| fifo_count | input | CNT_W | Characters held in the receive FIFO |
| head_err | input | 3 | Error tags of the FIFO head character (0 parity, 1 framing, 2 break) |
| rbr_read | input | 1 | Receive buffer read strobe |
| lsr_read | input | 1 | Line status read strobe |
| store_en | output | 1 | Store may accept the finished character |
| data_ready | output | 1 | Received data available |
| overrun | output | 1 | Overrun error flag |
| parity_err | output | 1 | Parity error flag |
| framing_err | output | 1 | Framing error flag |
| break_int | output | 1 | Break indication flag |
| line_irq | output | 1 | Receiver line status interrupt request |

## Verification
Holding-register mode is tried with isolated characters, back-to-back characters without a read, and a character arriving in the same cycle as a buffer read. Together these separate a real overrun from a read that frees the register just in time. FIFO mode is tried with characters carrying different error tags, pushed and then popped in several orders. This shows that each flag appears when its own character reaches the head, and not when it is received. A fill to full followed by one extra character shows that the extra character is dropped with overrun set. Status reads that coincide with fresh errors show that the new event is kept.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int N_ERR   = 4;
  localparam int IDX_OE  = 0;
  localparam int IDX_PE  = 1;
  localparam int IDX_FE  = 2;
  localparam int IDX_BI  = 3;
  localparam int TAG_PAR = 0;
  localparam int TAG_FRM = 1;
  localparam int TAG_BRK = 2;
  localparam int TAG_W   = 3;
endpackage

// File: rtl/lsr_occupancy.sv
module lsr_occupancy #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic             char_done,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             rbr_read,
  output logic             store_en,
  output logic             data_ready,
  output logic             overrun_evt,
  output logic             head_new
);
  localparam int SUM_W = CNT_W + 1;

  logic             pop;
  logic [SUM_W-1:0] occ_next;
  logic             dr_next;
  logic             lost_nf;
  logic             lost_ff;

  assign pop      = rbr_read & ~fifo_empty;
  assign store_en = char_done & (~fifo_mode | ~fifo_full | rbr_read);

  assign lost_nf     = data_ready & ~rbr_read;
  assign lost_ff     = fifo_full & ~rbr_read;
  assign overrun_evt = char_done & (fifo_mode ? lost_ff : lost_nf);

  assign occ_next = {1'b0, fifo_count} + SUM_W'(store_en) - SUM_W'(pop);

  always_comb begin
    if (fifo_mode) begin
      dr_next  = (occ_next != '0);
      head_new = pop ? ((fifo_count > CNT_W'(1)) | store_en) : (store_en & fifo_empty);
    end else begin
      dr_next  = char_done | (data_ready & ~rbr_read);
      head_new = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) data_ready <= 1'b0;
    else     data_ready <= dr_next;
  end

  // R2
  nf_dr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!fifo_mode && char_done) |=> data_ready);

  // R6
  idle_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    !char_done |-> !store_en);
endmodule

// File: rtl/lsr_err_bits.sv
module lsr_err_bits #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] bits,
  output logic         irq
);
  logic [N-1:0] nxt;

  for (genvar i = 0; i < N; i++) begin : g_flag
    assign nxt[i] = (bits[i] & ~clr) | set[i];

    always_ff @(posedge clk) begin
      if (rst) bits[i] <= 1'b0;
      else     bits[i] <= nxt[i];
    end

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr && !set[i]) |=> !bits[i]);

    // R9
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> bits[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |nxt;
  end
endmodule

// File: rtl/uart_rx_line_status.sv
module uart_rx_line_status
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic             char_done,
  input  logic             char_par_err,
  input  logic             char_frm_err,
  input  logic             char_brk,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [2:0]       head_err,
  input  logic             rbr_read,
  input  logic             lsr_read,
  output logic             store_en,
  output logic             data_ready,
  output logic             overrun,
  output logic             parity_err,
  output logic             framing_err,
  output logic             break_int,
  output logic             line_irq
);
  logic             overrun_evt;
  logic             head_new;
  logic             head_fresh_q;
  logic [TAG_W-1:0] char_tag;
  logic [TAG_W-1:0] tag_sel;
  logic [N_ERR-1:0] err_set;
  logic [N_ERR-1:0] err_bits;

  lsr_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
    .clk        (clk),
    .rst        (rst),
    .fifo_mode  (fifo_mode),
    .char_done  (char_done),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_count (fifo_count),
    .rbr_read   (rbr_read),
    .store_en   (store_en),
    .data_ready (data_ready),
    .overrun_evt(overrun_evt),
    .head_new   (head_new)
  );

  always_ff @(posedge clk) begin
    if (rst) head_fresh_q <= 1'b0;
    else     head_fresh_q <= head_new;
  end

  always_comb begin
    char_tag          = '0;
    char_tag[TAG_PAR] = char_par_err;
    char_tag[TAG_FRM] = char_frm_err;
    char_tag[TAG_BRK] = char_brk;
    if (fifo_mode) tag_sel = head_fresh_q ? head_err : '0;
    else           tag_sel = char_done ? char_tag : '0;
    err_set         = '0;
    err_set[IDX_OE] = overrun_evt;
    err_set[IDX_PE] = tag_sel[TAG_PAR];
    err_set[IDX_FE] = tag_sel[TAG_FRM];
    err_set[IDX_BI] = tag_sel[TAG_BRK];
  end

  lsr_err_bits #(.N(N_ERR)) u_err (
    .clk (clk),
    .rst (rst),
    .clr (lsr_read),
    .set (err_set),
    .bits(err_bits),
    .irq (line_irq)
  );

  assign overrun     = err_bits[IDX_OE];
  assign parity_err  = err_bits[IDX_PE];
  assign framing_err = err_bits[IDX_FE];
  assign break_int   = err_bits[IDX_BI];

  // R4
  nf_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (!fifo_mode && char_done && data_ready && !rbr_read) |=> overrun);

  // R5
  full_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_mode && char_done && fifo_full && !rbr_read) |=> (overrun && !$past(store_en)));

  // R10
  irq_sum_chk: assert property (@(posedge clk) disable iff (rst)
    line_irq == (overrun | parity_err | framing_err | break_int));

  // R4
  oe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(char_done));
endmodule

// File: tb/uart_rx_line_status_test.sv
module uart_rx_line_status_test;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, fifo_mode = 1'b0, char_done = 1'b0;
  logic char_par_err = 1'b0, char_frm_err = 1'b0, char_brk = 1'b0;
  logic fifo_full = 1'b0, fifo_empty = 1'b1;
  logic [CW-1:0] fifo_count = '0;
  logic [2:0] head_err = '0;
  logic rbr_read = 1'b0, lsr_read = 1'b0;
  logic store_en, data_ready, overrun, parity_err, framing_err, break_int, line_irq;

  uart_rx_line_status #(.DEPTH(DEPTH), .CNT_W(CW)) uut (.*);

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [2:0] q_tag[$];
  int q_dat[$];
  int next_dat = 0;
  bit m_dr, m_oe, m_pe, m_fe, m_bi, m_fresh;

  task automatic chk(string req, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset(bit mode);
    @(negedge clk);
    rst = 1'b1; fifo_mode = mode; char_done = 0; rbr_read = 0; lsr_read = 0;
    char_par_err = 0; char_frm_err = 0; char_brk = 0;
    q_tag.delete(); q_dat.delete();
    fifo_full = 0; fifo_empty = 1; fifo_count = '0; head_err = '0;
    repeat (2) @(negedge clk);
    // R1 outputs during reset
    chk("R1", "outputs in reset", |{data_ready, overrun, parity_err, framing_err, break_int, line_irq}, 1'b0);
    rst = 1'b0;
    {m_dr, m_oe, m_pe, m_fe, m_bi, m_fresh} = '0;
    @(posedge clk); #1;
    chk("R1", "outputs after reset", |{data_ready, overrun, parity_err, framing_err, break_int, line_irq}, 1'b0);
  endtask

  task automatic step(bit cd, bit p, bit f, bit b, bit rd, bit lr);
    int  cnt;
    bit  exp_store, oe_ev, sp, sf, sb, popped, was_empty;
    @(negedge clk);
    cnt = q_tag.size();
    char_done = cd; char_par_err = p; char_frm_err = f; char_brk = b;
    rbr_read = rd; lsr_read = lr;
    fifo_count = CW'(cnt);
    fifo_full  = (cnt == DEPTH);
    fifo_empty = (cnt == 0);
    head_err   = (cnt == 0) ? 3'b000 : q_tag[0];
    #1;
    exp_store = cd && (!fifo_mode || cnt < DEPTH || rd);
    chk(fifo_mode ? "R5" : "R6", "store_en", store_en, exp_store);
    oe_ev = cd && !rd && (fifo_mode ? (cnt == DEPTH) : m_dr);
    if (fifo_mode) begin
      sp = m_fresh && head_err[0]; sf = m_fresh && head_err[1]; sb = m_fresh && head_err[2];
      was_empty = (cnt == 0);
      popped = 0;
      if (rd && cnt > 0) begin void'(q_tag.pop_front()); void'(q_dat.pop_front()); popped = 1; end
      if (exp_store) begin q_tag.push_back({b, f, p}); q_dat.push_back(next_dat); end
      m_fresh = (q_tag.size() > 0) && (popped || was_empty);
      m_dr = (q_tag.size() != 0);
    end else begin
      sp = cd && p; sf = cd && f; sb = cd && b;
      m_fresh = 0;
      m_dr = cd || (m_dr && !rd);
    end
    if (cd) next_dat++;
    m_oe = (m_oe && !lr) || oe_ev;
    m_pe = (m_pe && !lr) || sp;
    m_fe = (m_fe && !lr) || sf;
    m_bi = (m_bi && !lr) || sb;
    @(posedge clk); #1;
    chk(fifo_mode ? "R3" : "R2", "data_ready", data_ready, m_dr);
    chk(fifo_mode ? "R5" : "R4", "overrun", overrun, m_oe);
    chk(fifo_mode ? "R8" : "R7", "parity_err", parity_err, m_pe);
    chk(fifo_mode ? "R8" : "R7", "framing_err", framing_err, m_fe);
    chk(fifo_mode ? "R8" : "R7", "break_int", break_int, m_bi);
    chk("R10", "line_irq", line_irq, m_oe | m_pe | m_fe | m_bi);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int snap[$];
    bit same;
    // ---------------- holding-register mode ----------------
    do_reset(1'b0);
    step(1, 0, 0, 0, 0, 0); idle(1);
    chk("R2", "ready after char", data_ready, 1'b1);
    step(0, 0, 0, 0, 1, 0); idle(1);
    chk("R2", "ready cleared by read", data_ready, 1'b0);
    step(1, 0, 0, 0, 0, 0); idle(1);
    step(1, 0, 0, 0, 0, 0); idle(1);
    chk("R4", "overrun on unread char", overrun, 1'b1);
    chk("R6", "no stray store", store_en, 1'b0);
    step(0, 0, 0, 0, 0, 1);
    chk("R9", "overrun cleared by lsr read", overrun, 1'b0);
    step(1, 0, 0, 0, 1, 0); idle(1);
    chk("R4", "read same cycle avoids overrun", overrun, 1'b0);
    step(0, 0, 0, 0, 1, 0);
    step(1, 1, 0, 0, 0, 0);
    chk("R7", "parity captured", parity_err, 1'b1);
    chk("R10", "irq on parity", line_irq, 1'b1);
    step(1, 0, 1, 1, 1, 1);
    chk("R9", "new framing wins over read", framing_err, 1'b1);
    chk("R9", "old parity cleared", parity_err, 1'b0);
    step(0, 0, 0, 0, 1, 1); idle(1);
    chk("R10", "irq low when clear", line_irq, 1'b0);

    // ---------------- FIFO mode ----------------
    do_reset(1'b1);
    step(1, 0, 0, 0, 0, 0); idle(1);
    step(1, 1, 0, 0, 0, 0); idle(1);
    step(1, 0, 0, 1, 0, 0); idle(2);
    chk("R8", "parity not raised before reaching head", parity_err, 1'b0);
    chk("R3", "ready with data", data_ready, 1'b1);
    step(0, 0, 0, 0, 1, 0); idle(2);
    chk("R8", "parity raised at head", parity_err, 1'b1);
    step(0, 0, 0, 0, 1, 1); idle(2);
    chk("R8", "break raised at head", break_int, 1'b1);
    chk("R9", "parity cleared by read", parity_err, 1'b0);
    step(0, 0, 0, 0, 1, 1); idle(1);
    chk("R3", "ready clears when empty", data_ready, 1'b0);
    // push and pop together at count 1
    step(1, 0, 0, 0, 0, 0); idle(1);
    step(1, 0, 1, 0, 1, 0); idle(2);
    chk("R8", "framing when push+pop at count 1", framing_err, 1'b1);
    step(0, 0, 0, 0, 1, 1); idle(1);
    // fill to full
    for (int i = 0; i < DEPTH; i++) begin step(1, 0, 0, 0, 0, 0); idle(1); end
    chk("R5", "fifo full", fifo_full, 1'b1);
    snap = q_dat;
    step(1, 1, 0, 0, 0, 0);
    chk("R5", "overrun when full", overrun, 1'b1);
    same = (snap.size() == q_dat.size());
    if (same) foreach (snap[k]) if (snap[k] != q_dat[k]) same = 0;
    chk("R5", "fifo contents unchanged", same, 1'b1);
    idle(1);
    step(0, 0, 0, 0, 0, 1);
    chk("R9", "overrun cleared after one lsr read", overrun, 1'b0);
    step(1, 0, 0, 0, 1, 0); idle(1);
    chk("R5", "full with read same cycle no overrun", overrun, 1'b0);
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 0, 1, 0);
    idle(2);
    chk("R3", "drained", data_ready, 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule